// File: doc/BRIEF.md
# SPI FIFO Event and Interrupt Unit

This block sits between a processor-side register port and the byte-serial shift engine of an SPI controller. It buffers outgoing bytes in a transmit FIFO and incoming bytes in a receive FIFO, both 32 bytes deep by default. It also keeps a small event register that software polls or takes interrupts from. Software pushes data with 32-bit writes, which load four bytes at once, or with byte-wide writes. It drains received data with 32-bit reads, which pop four bytes, or with byte-wide reads, so a tail shorter than a word can still be collected.

The event register carries live fill counts for both FIFOs. Beside them are two level-derived flags and two sticky error flags. The first flag reports that the receive FIFO holds more bytes than a software threshold. The second reports that the transmit FIFO has more free space than a software threshold. The error flags mark a transmit write that did not fit and a receive read that found too few bytes. Flags are cleared by writing ones. One interrupt line is the registered OR of the flags enabled by a mask register.

On the engine side, both byte streams use valid/ready. A byte moves only in a cycle where valid and ready are both high. The transmit side holds `tx_valid` high and `tx_data` stable while the FIFO is non-empty and the engine is not ready. The receive side drops `rx_ready` while the FIFO is full, and the engine must hold its byte until it is accepted.

Top module: `spi_fifo_evt`

## Requirements
- R1: After reset, both FIFOs are empty, `tx_valid` and `irq` are low and `rx_ready` is high. The mask register (0x08) reads 0. The mode register (0x00) reads 0x0000_0403: transmit threshold 4 in bits [13:8], receive threshold 3 in bits [5:0].
- R2: A write to 0x10 with `reg_byte`=0 pushes four bytes, `reg_wdata[31:24]` first and `[7:0]` last. With `reg_byte`=1 it pushes only `reg_wdata[7:0]`. `tx_data` is the oldest byte, and it leaves the FIFO on a cycle with `tx_valid` and `tx_ready` both high.
- R3: A transmit write that needs more bytes than the FIFO has free pushes nothing and sets the sticky transmit-overflow flag, event bit 10.
- R4: `rx_ready` is high exactly while the receive FIFO holds fewer than DEPTH bytes. A byte on `rx_data` is stored on a cycle with `rx_valid` and `rx_ready` both high. While the FIFO is full, `rx_valid` has no effect.
- R5: A read of 0x14 with `reg_byte`=0 pops four bytes and returns the oldest in bits [31:24], through the fourth oldest in [7:0]. With `reg_byte`=1 it pops one byte, returned in [7:0] with [31:8] zero.
- R6: A receive read that needs more bytes than the FIFO holds pops nothing and sets the sticky receive-underflow flag, event bit 11.
- R7: The event register (0x04) shows the live receive count in bits [29:24] and the live transmit count in bits [21:16].
- R8: Event bit 9 is set on every cycle in which the receive count exceeds the receive threshold. Event bit 8 is set on every cycle in which DEPTH minus the transmit count exceeds the transmit threshold. Each bit takes effect one cycle after the condition.
- R9: Writing 0x04 clears each of event bits [11:8] whose data bit is one. If a set condition is true in the same cycle as a clear, the set wins.
- R10: The mask register keeps bits [11:8] and reads 0 elsewhere. `irq` goes high one cycle after an event bit and its mask bit are both set, and goes low one cycle after no masked event bit remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on the receive data address) |
| reg_byte | input | 1 | 1 = byte-wide access, 0 = 32-bit access |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| tx_valid | output | 1 | Transmit FIFO holds a byte |
| tx_ready | input | 1 | Shift engine takes the byte this cycle |
| tx_data | output | 8 | Oldest transmit byte |
| rx_valid | input | 1 | Shift engine offers a received byte |
| rx_ready | output | 1 | Receive FIFO has room |
| rx_data | input | 8 | Received byte |
| irq | output | 1 | Registered OR of masked event bits |

## Verification
The hardest situation to reach is the threshold flags with the FIFO count and the threshold each at a chosen value, in both directions of the comparison. The flags are sticky, so a stale set hides the current comparison. The bench therefore grows each FIFO one byte at a time and, at every fill level, sweeps the threshold across the boundary. For each pair it rewrites the mode register, clears the flag and only then reads it back. The one-cycle lag of `irq` is pinned by causing an overflow and a mask change and sampling `irq` on both sides of the following edge.

// File: rtl/spi_fifo_evt_pkg.sv
package spi_fifo_evt_pkg;
  // register byte addresses
  localparam logic [7:0] A_MODE = 8'h00;
  localparam logic [7:0] A_EVT  = 8'h04;
  localparam logic [7:0] A_MASK = 8'h08;
  localparam logic [7:0] A_TXD  = 8'h10;
  localparam logic [7:0] A_RXD  = 8'h14;

  // field positions
  localparam int THR_W     = 6;
  localparam int TXTHR_LSB = 8;
  localparam int RXTHR_LSB = 0;
  localparam int CNT_FW    = 6;
  localparam int RXCNT_LSB = 24;
  localparam int TXCNT_LSB = 16;
  localparam int EV_LO     = 8;
  localparam int EV_N      = 4;

  localparam logic [THR_W-1:0] TXTHR_RST = 6'd4;
  localparam logic [THR_W-1:0] RXTHR_RST = 6'd3;

  // event bits, msb = bit 11 down to bit 8
  typedef struct packed {
    logic rx_udf;  // bit 11
    logic tx_ovf;  // bit 10
    logic rx_ne;   // bit 9
    logic tx_nf;   // bit 8
  } evt_t;
endpackage

// File: rtl/sfe_byte_fifo.sv
// Byte FIFO that moves 0..LANES bytes in and 0..LANES bytes out per cycle.
// DEPTH must be a power of two. Callers never ask for more than fits or is held.
module sfe_byte_fifo #(
  parameter int DEPTH = 32,
  parameter int LANES = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1,
  localparam int NW = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NW-1:0]     push_n,
  input  logic [LANES*8-1:0] push_bytes,
  input  logic [NW-1:0]     pop_n,
  output logic [CW-1:0]     cnt,
  output logic [LANES*8-1:0] peek
);
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt_q;
  logic [7:0]    mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      cnt_q <= '0;
    end else begin
      wp    <= wp + AW'(push_n);
      rp    <= rp + AW'(pop_n);
      cnt_q <= cnt_q + CW'(push_n) - CW'(pop_n);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (NW'(i) < push_n) mem[wp + AW'(i)] <= push_bytes[i*8 +: 8];
    end
  end

  // byte 0 of peek is the oldest entry
  for (genvar g = 0; g < LANES; g++) begin : g_peek
    assign peek[g*8 +: 8] = mem[rp + AW'(g)];
  end

  assign cnt = cnt_q;

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(push_n) <= CW'(DEPTH) - cnt_q)
    else $error("fifo pushed past its depth");
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(pop_n) <= cnt_q)
    else $error("fifo popped more than it held");
  p_count_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_n == '0 && pop_n == '0) |=> $stable(cnt_q))
    else $error("fifo count moved without traffic");
endmodule

// File: rtl/sfe_evt_irq.sv
// Event flags, mask register and registered interrupt.
module sfe_evt_irq
  import spi_fifo_evt_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    rx_cnt,
  input  logic [CW-1:0]    tx_cnt,
  input  logic [THR_W-1:0] rx_thr,
  input  logic [THR_W-1:0] tx_thr,
  input  logic             tx_ovf_hit,
  input  logic             rx_udf_hit,
  input  logic             clr_we,
  input  logic [EV_N-1:0]  clr_bits,
  input  logic             mask_we,
  input  logic [EV_N-1:0]  mask_bits,
  output evt_t             evt,
  output logic [EV_N-1:0]  mask,
  output logic             irq
);
  evt_t set_now, evt_q;
  logic [EV_N-1:0] mask_q;
  logic            irq_q;
  logic [EV_N-1:0] clr_eff;

  always_comb begin
    set_now.rx_ne  = int'(rx_cnt) > int'(rx_thr);
    set_now.tx_nf  = (DEPTH - int'(tx_cnt)) > int'(tx_thr);
    set_now.tx_ovf = tx_ovf_hit;
    set_now.rx_udf = rx_udf_hit;
    clr_eff        = clr_we ? clr_bits : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      evt_q <= (evt_q & ~clr_eff) | set_now;  // a new set beats a clear
      if (mask_we) mask_q <= mask_bits;
      irq_q <= |(evt_q & mask_q);
    end
  end

  assign evt  = evt_q;
  assign mask = mask_q;
  assign irq  = irq_q;

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q.tx_ovf && !clr_eff[2]) |=> evt_q.tx_ovf)
    else $error("overflow flag dropped without a clear");
  p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_eff[3] && !rx_udf_hit) |=> !evt_q.rx_udf)
    else $error("underflow flag survived a clear");
  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> !irq_q)
    else $error("irq raised with every mask bit off");
endmodule

// File: rtl/spi_fifo_evt.sv
module spi_fifo_evt
  import spi_fifo_evt_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic        reg_byte,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  output logic        irq
);
  localparam int LANES = 4;
  localparam int CW    = $clog2(DEPTH) + 1;
  localparam int NW    = $clog2(LANES + 1);

  logic [THR_W-1:0]   tx_thr_q, rx_thr_q;
  logic [CW-1:0]      tx_cnt, rx_cnt, tx_free, acc_n;
  logic [LANES*8-1:0] tx_peek, rx_peek, tx_lanes, rx_lanes;
  logic [NW-1:0]      tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
  logic               wr_mode, wr_evt, wr_mask, wr_txd, rd_rxd;
  logic               tx_ovf, rx_udf;
  evt_t               evt;
  logic [EV_N-1:0]    mask;

  // decode
  assign wr_mode = reg_wr && reg_addr == A_MODE;
  assign wr_evt  = reg_wr && reg_addr == A_EVT;
  assign wr_mask = reg_wr && reg_addr == A_MASK;
  assign wr_txd  = reg_wr && reg_addr == A_TXD;
  assign rd_rxd  = reg_rd && reg_addr == A_RXD;
  assign acc_n   = reg_byte ? CW'(1) : CW'(LANES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_thr_q <= TXTHR_RST;
      rx_thr_q <= RXTHR_RST;
    end else if (wr_mode) begin
      tx_thr_q <= reg_wdata[TXTHR_LSB +: THR_W];
      rx_thr_q <= reg_wdata[RXTHR_LSB +: THR_W];
    end
  end

  // transmit side: word writes enter most significant byte first
  assign tx_free   = CW'(DEPTH) - tx_cnt;
  assign tx_ovf    = wr_txd && (acc_n > tx_free);
  assign tx_push_n = (wr_txd && !tx_ovf) ? NW'(acc_n) : '0;
  always_comb begin
    for (int i = 0; i < LANES; i++) tx_lanes[i*8 +: 8] = reg_wdata[(LANES-1-i)*8 +: 8];
    if (reg_byte) tx_lanes[7:0] = reg_wdata[7:0];
  end
  assign tx_valid = tx_cnt != '0;
  assign tx_data  = tx_peek[7:0];
  assign tx_pop_n = NW'(tx_valid && tx_ready);

  sfe_byte_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_txq (
    .clk(clk), .rst_n(rst_n), .push_n(tx_push_n), .push_bytes(tx_lanes),
    .pop_n(tx_pop_n), .cnt(tx_cnt), .peek(tx_peek));

  // receive side
  assign rx_ready  = rx_cnt != CW'(DEPTH);
  assign rx_push_n = NW'(rx_valid && rx_ready);
  assign rx_lanes  = {{(LANES-1)*8{1'b0}}, rx_data};
  assign rx_udf    = rd_rxd && (acc_n > rx_cnt);
  assign rx_pop_n  = (rd_rxd && !rx_udf) ? NW'(acc_n) : '0;

  sfe_byte_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push_n(rx_push_n), .push_bytes(rx_lanes),
    .pop_n(rx_pop_n), .cnt(rx_cnt), .peek(rx_peek));

  sfe_evt_irq #(.DEPTH(DEPTH)) u_evt (
    .clk(clk), .rst_n(rst_n), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
    .rx_thr(rx_thr_q), .tx_thr(tx_thr_q), .tx_ovf_hit(tx_ovf), .rx_udf_hit(rx_udf),
    .clr_we(wr_evt), .clr_bits(reg_wdata[EV_LO +: EV_N]),
    .mask_we(wr_mask), .mask_bits(reg_wdata[EV_LO +: EV_N]),
    .evt(evt), .mask(mask), .irq(irq));

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_MODE: begin
        reg_rdata[TXTHR_LSB +: THR_W] = tx_thr_q;
        reg_rdata[RXTHR_LSB +: THR_W] = rx_thr_q;
      end
      A_EVT: begin
        reg_rdata[RXCNT_LSB +: CNT_FW] = CNT_FW'(rx_cnt);
        reg_rdata[TXCNT_LSB +: CNT_FW] = CNT_FW'(tx_cnt);
        reg_rdata[EV_LO +: EV_N]       = evt;
      end
      A_MASK: reg_rdata[EV_LO +: EV_N] = mask;
      A_RXD: begin
        if (reg_byte) reg_rdata[7:0] = rx_peek[7:0];
        else for (int i = 0; i < LANES; i++) reg_rdata[(LANES-1-i)*8 +: 8] = rx_peek[i*8 +: 8];
      end
      default: reg_rdata = '0;
    endcase
  end

  p_tx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)))
    else $error("transmit byte changed while stalled");
  p_rx_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ready && !rd_rxd) |=> !rx_ready)
    else $error("full receive fifo gained room without a read");
endmodule

// File: tb/spi_fifo_evt_bench.sv
module spi_fifo_evt_bench;
  localparam int CLK_P = 10;
  localparam int DEPTH = 32;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0, reg_byte = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic tx_valid, tx_ready = 0, rx_valid = 0, rx_ready, irq;
  logic [7:0] tx_data, rx_data = 0;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  spi_fifo_evt #(.DEPTH(DEPTH)) u_spi_fifo_evt (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_byte(reg_byte),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .irq(irq));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit b);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d; reg_byte = b;
    @(negedge clk); reg_wr = 0; reg_byte = 0;
  endtask

  task automatic rd(input logic [7:0] a, input bit b, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; reg_byte = b;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0; reg_byte = 0;
  endtask

  task automatic rx_push(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_data = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic tx_pop(output logic v, output logic [7:0] d);
    @(negedge clk); tx_ready = 1;
    #1 v = tx_valid; d = tx_data;
    @(negedge clk); tx_ready = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic v;
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 tx_valid", {31'b0, tx_valid}, 0);
    chk("R1 rx_ready", {31'b0, rx_ready}, 1);
    rd(8'h00, 0, d); chk("R1 mode", d, 32'h0000_0403);
    rd(8'h08, 0, d); chk("R1 mask", d, 0);
    rd(8'h04, 0, d); chk("R8 nf after reset", d, 32'h0000_0100);

    // R9 write-one-to-clear and re-set
    wr(8'h00, 32'h0000_2003, 0);   // tx threshold 32: not-full never true
    wr(8'h04, 32'hFFFF_FFFF, 0);
    rd(8'h04, 0, d); chk("R9 cleared", d, 0);
    wr(8'h00, 32'h0000_0403, 0);
    rd(8'h04, 0, d); chk("R9 reasserts", d, 32'h0000_0100);
    wr(8'h04, 32'h0000_0100, 0);
    rd(8'h04, 0, d); chk("R9 set wins over clear", d, 32'h0000_0100);

    // R2/R7 transmit word fill
    for (int w = 0; w < 8; w++) begin
      logic [7:0] b0;
      b0 = 8'(8'h10 + w*4);
      wr(8'h10, {b0, b0 + 8'd1, b0 + 8'd2, b0 + 8'd3}, 0);
      rd(8'h04, 0, d); chk("R7 tx count", 32'(d[21:16]), 32'(4*(w+1)));
    end
    // R3 overflow at full
    wr(8'h04, 32'hFFFF_FFFF, 0);
    wr(8'h10, 32'hDEAD_BEEF, 0);
    rd(8'h04, 0, d); chk("R3 ovf word", {d[21:16], 16'b0, d[10]}, {6'd32, 16'b0, 1'b1});
    wr(8'h04, 32'h0000_0400, 0);
    wr(8'h10, 32'h0000_0077, 1);
    rd(8'h04, 0, d); chk("R3 ovf byte", {d[21:16], d[10]}, {6'd32, 1'b1});
    // R2 drain in order
    for (int k = 0; k < 32; k++) begin
      tx_pop(v, b);
      chk("R2 tx order", {23'b0, v, b}, {23'b0, 1'b1, 8'(8'h10 + k)});
    end
    #1 chk("R2 tx empty", {31'b0, tx_valid}, 0);
    wr(8'h10, 32'hAABB_CC5A, 1);
    rd(8'h04, 0, d); chk("R2 byte write count", 32'(d[21:16]), 1);
    tx_pop(v, b); chk("R2 byte write data", {23'b0, v, b}, {23'b0, 1'b1, 8'h5A});

    // R4 receive fill
    for (int k = 0; k < 32; k++) begin
      @(negedge clk); #1 chk("R4 ready while room", {31'b0, rx_ready}, 1);
      rx_push(8'(8'h40 + k));
    end
    #1 chk("R4 not ready when full", {31'b0, rx_ready}, 0);
    rx_push(8'hEE);
    rd(8'h04, 0, d); chk("R4 full ignores push", 32'(d[29:24]), 32);
    // R5 word and byte reads
    rd(8'h14, 0, d); chk("R5 word read", d, 32'h4041_4243);
    rd(8'h14, 1, d); chk("R5 byte read", d, 32'h0000_0044);
    rd(8'h14, 0, d); chk("R5 word read 2", d, 32'h4546_4748);
    rd(8'h04, 0, d); chk("R7 rx count", 32'(d[29:24]), 23);
    for (int k = 0; k < 20; k++) begin
      rd(8'h14, 1, d); chk("R5 byte drain", d, 32'(8'h49 + k));
    end
    // R6 underflow with 3 left
    wr(8'h04, 32'hFFFF_FFFF, 0);
    rd(8'h14, 0, d);
    rd(8'h04, 0, d); chk("R6 word underflow", {d[29:24], d[11]}, {6'd3, 1'b1});
    for (int k = 0; k < 3; k++) begin
      rd(8'h14, 1, d); chk("R6 tail bytes", d, 32'(8'h5D + k));
    end
    wr(8'h04, 32'hFFFF_FFFF, 0);
    rd(8'h14, 1, d);
    rd(8'h04, 0, d); chk("R6 byte underflow", {d[29:24], d[11]}, {6'd0, 1'b1});

    // R8 receive threshold sweep
    for (int c = 0; c <= 8; c++) begin
      for (int t = 0; t < 8; t++) begin
        wr(8'h00, 32'h0000_0400 | 32'(t), 0);
        wr(8'h04, 32'h0000_0200, 0);
        rd(8'h04, 0, d); chk("R8 rx ne", 32'(d[9]), 32'(c > t));
      end
      rx_push(8'(c));
    end
    // R8 transmit threshold sweep
    for (int c = 0; c <= 8; c++) begin
      for (int t = 24; t < 32; t++) begin
        wr(8'h00, 32'(t) << 8 | 32'h3, 0);
        wr(8'h04, 32'h0000_0100, 0);
        rd(8'h04, 0, d); chk("R8 tx nf", 32'(d[8]), 32'((32 - c) > t));
      end
      wr(8'h10, 32'(c), 1);
    end
    wr(8'h00, 32'h0000_0403, 0);
    for (int k = 0; k < 9; k++) rd(8'h14, 1, d);
    for (int k = 0; k < 9; k++) tx_pop(v, b);

    // R10 interrupt timing
    wr(8'h04, 32'hFFFF_FFFF, 0);
    wr(8'h08, 32'h0000_0400, 0);
    rd(8'h08, 0, d); chk("R10 mask readback", d, 32'h0000_0400);
    #1 chk("R10 irq idle", {31'b0, irq}, 0);
    for (int w = 0; w < 8; w++) wr(8'h10, 32'h1234_5678, 0);
    wr(8'h10, 32'h1234_5678, 0);
    #1 chk("R10 irq one cycle late", {31'b0, irq}, 0);
    @(posedge clk); #1 chk("R10 irq rises", {31'b0, irq}, 1);
    wr(8'h08, 32'h0, 0);
    #1 chk("R10 irq still high", {31'b0, irq}, 1);
    @(posedge clk); #1 chk("R10 irq falls on mask", {31'b0, irq}, 0);
    wr(8'h08, 32'h0000_0400, 0);
    @(posedge clk); #1 chk("R10 irq back", {31'b0, irq}, 1);
    wr(8'h04, 32'h0000_0400, 0);
    @(posedge clk); #1 chk("R9 clear drops irq", {31'b0, irq}, 0);
    wr(8'h08, 32'hFFFF_FFFF, 0);
    rd(8'h08, 0, d); chk("R10 mask width", d, 32'h0000_0F00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule